// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash model. It watches the flash bus (address, write data, active-low write strobe, output enable and chip enable) in a synchronous clock domain. It recognises multi-write unlock sequences that protect every change to stored data. A completed program or erase sequence raises a one-cycle start pulse that carries the operation kind, address and data toward the array model. The block then stays busy for a parameterised number of clock cycles.

While busy, reads return a status word whose bit 6 flips on each completed read, and every write is ignored. A separate identification mode returns a manufacturer code and a parameterised device code on reads, and is left only through its own exit sequence. In any other state, reads pass the array data through unchanged.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset busy_o and op_valid_o are 0, the block is in read mode, and rdata_o equals array_rdata_i.
- R2: The writes 0x5555/0xAA, 0x2AAA/0x55 and 0x5555/0xA0, followed by one more write, start a program. In the cycle after that fourth write, op_valid_o pulses with op_kind_o=1 and op_addr_o/op_data_o set to that write's address and data. busy_o is then high for exactly PROG_CYC cycles.
- R3: The writes AA@0x5555, 55@0x2AAA, 80@0x5555, AA@0x5555 and 55@0x2AAA, followed by a sixth write, start an erase. A sixth write of data 0x30 at any address is a sector erase: op_kind_o=2, op_addr_o is that address, and busy lasts SECT_CYC cycles. A sixth write of 0x10 at 0x5555 is a bank erase: op_kind_o=3, and busy lasts CHIP_CYC cycles. Only the low data byte is compared.
- R4: A write that does not match the next expected cycle aborts the sequence to read mode. Later command bytes without a fresh unlock start nothing.
- R5: While busy_o is high every write is ignored. This includes the ID entry and ID exit sequences, and no start pulse is produced.
- R6: The writes AA@0x5555, 55@0x2AAA and 90@0x5555 enter ID mode. In ID mode a read at address 0 returns 0x00BF, at address 1 returns DEV_ID, and at any other address returns 0x0000.
- R7: ID mode persists across unrelated writes. Only AA@0x5555, 55@0x2AAA, F0@0x5555 returns the block to array reads.
- R8: A write is taken only at the rising edge of we_ni while ce_ni is low and oe_ni is high. Strobes with oe_ni low or ce_ni high are ignored and do not disturb a pending sequence.
- R9: While busy, rdata_o is 0x0000 except bit 6. Bit 6 is 0 on the first read after the start and inverts at the end of each read, which is the rising oe_ni while ce_ni is low and we_ni is high.
- R10: When the busy time ends, busy_o falls and rdata_o returns to array_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus word address |
| wdata_i | input | DATA_W | Bus write data |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| ce_ni | input | 1 | Chip enable, active low |
| array_rdata_i | input | DATA_W | Data from the array model |
| rdata_o | output | DATA_W | Read data, status or ID code |
| busy_o | output | 1 | Internal program or erase in progress |
| op_valid_o | output | 1 | One-cycle start pulse |
| op_kind_o | output | 2 | 1 program, 2 sector erase, 3 bank erase |
| op_addr_o | output | ADDR_W | Address of the started operation |
| op_data_o | output | DATA_W | Data of the started operation |

## Verification
The assertions assume that the bus pins are synchronous to clk_i and that address and data are stable across the clock edge where a rising write strobe is seen. They also assume that the write strobe and output enable are never low at the same time during a plain read. The bench drives every pin on the falling clock edge and holds address and data from the falling strobe until one cycle after it rises. It lowers output enable only for reads or for the deliberately gated write case.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PDATA,
    SQ_ERA1,
    SQ_ERA2,
    SQ_ERA3
  } seq_e;

  localparam logic [15:0] UNL_ADDR_A = 16'h5555;
  localparam logic [15:0] UNL_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNL_BYTE_A = 8'hAA;
  localparam logic [7:0]  UNL_BYTE_B = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_ID_IN  = 8'h90;
  localparam logic [7:0]  CMD_ID_OUT = 8'hF0;
  localparam logic [15:0] MFR_CODE   = 16'h00BF;
  localparam int unsigned TOGGLE_BIT = 6;
endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic ce_ni,
  output logic wr_stb_o,
  output logic rd_end_o
);
  logic we_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
    end
  end

  // write taken on strobe rise, only with chip enabled and outputs off
  assign wr_stb_o = !we_q && we_ni && !ce_ni && oe_ni;
  assign rd_end_o = !oe_q && oe_ni && !ce_ni && we_ni;
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              start_o,
  output op_kind_e          kind_o,
  output logic              id_mode_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNL_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNL_ADDR_B);

  seq_e seq_q, seq_d;
  logic id_q, id_d;
  logic [7:0] byte_w;
  logic at_a, at_b;

  assign byte_w = wdata_i[7:0];
  assign at_a   = (addr_i == ADR_A);
  assign at_b   = (addr_i == ADR_B);

  always_comb begin
    seq_d   = seq_q;
    id_d    = id_q;
    start_o = 1'b0;
    kind_o  = OP_NONE;
    if (wr_stb_i && !busy_i) begin
      seq_d = SQ_IDLE;  // any mismatch aborts
      unique case (seq_q)
        SQ_IDLE: if (at_a && byte_w == UNL_BYTE_A) seq_d = SQ_UNL1;
        SQ_UNL1: if (at_b && byte_w == UNL_BYTE_B) seq_d = SQ_UNL2;
        SQ_UNL2: begin
          if (at_a) begin
            unique case (byte_w)
              CMD_PROG:   if (!id_q) seq_d = SQ_PDATA;
              CMD_ERASE:  if (!id_q) seq_d = SQ_ERA1;
              CMD_ID_IN:  id_d = 1'b1;
              CMD_ID_OUT: id_d = 1'b0;
              default:    seq_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PDATA: begin
          start_o = 1'b1;
          kind_o  = OP_PROG;
        end
        SQ_ERA1: if (at_a && byte_w == UNL_BYTE_A) seq_d = SQ_ERA2;
        SQ_ERA2: if (at_b && byte_w == UNL_BYTE_B) seq_d = SQ_ERA3;
        SQ_ERA3: begin
          if (byte_w == CMD_SECT) begin
            start_o = 1'b1;
            kind_o  = OP_SECT;
          end else if (at_a && byte_w == CMD_CHIP) begin
            start_o = 1'b1;
            kind_o  = OP_CHIP;
          end
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SQ_IDLE;
      id_q  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      id_q  <= id_d;
    end
  end

  assign id_mode_o = id_q;

  // R4: sequence state moves only on an accepted bus write
  a_r4_seq_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(seq_q));
  // R5: nothing is decoded while an operation runs
  a_r5_idle_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (seq_q == SQ_IDLE) && $stable(id_q));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 1000,
  parameter int unsigned CHIP_CYC = 5000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_kind_e kind_i,
  input  logic     rd_end_i,
  output logic     busy_o,
  output logic     toggle_o
);
  localparam int unsigned MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_CYC = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, load_w;
  logic busy_q, tgl_q;

  always_comb begin
    unique case (kind_i)
      OP_SECT: load_w = CNT_W'(SECT_CYC - 1);
      OP_CHIP: load_w = CNT_W'(CHIP_CYC - 1);
      default: load_w = CNT_W'(PROG_CYC - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_w;
      busy_q <= 1'b1;
      tgl_q  <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (rd_end_i) tgl_q <= ~tgl_q;
    end
  end

  assign busy_o   = busy_q;
  assign toggle_o = tgl_q;

  // R9: toggle frozen outside an operation
  a_r9_toggle_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(tgl_q));
  // R10: counter never runs while idle
  a_r10_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h2781
) (
  input  logic              busy_i,
  input  logic              toggle_i,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = array_i;
    if (busy_i) begin
      rdata_o = '0;
      rdata_o[TOGGLE_BIT] = toggle_i;
    end else if (id_mode_i) begin
      if (addr_i == ADDR_W'(0))      rdata_o = DATA_W'(MFR_CODE);
      else if (addr_i == ADDR_W'(1)) rdata_o = DEV_ID;
      else                           rdata_o = '0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h2781,
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 1000,
  parameter int unsigned CHIP_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              ce_ni,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              op_valid_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  logic wr_stb, rd_end, start_w, busy_w, tgl_w, id_mode;
  op_kind_e kind_w;

  flash_bus_edge i_edge (
    .clk_i, .rst_ni, .we_ni, .oe_ni, .ce_ni,
    .wr_stb_o (wr_stb),
    .rd_end_o (rd_end)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni,
    .wr_stb_i  (wr_stb),
    .busy_i    (busy_w),
    .addr_i,
    .wdata_i,
    .start_o   (start_w),
    .kind_o    (kind_w),
    .id_mode_o (id_mode)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) i_timer (
    .clk_i, .rst_ni,
    .start_i  (start_w),
    .kind_i   (kind_w),
    .rd_end_i (rd_end),
    .busy_o   (busy_w),
    .toggle_o (tgl_w)
  );

  flash_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) i_rmux (
    .busy_i    (busy_w),
    .toggle_i  (tgl_w),
    .id_mode_i (id_mode),
    .addr_i,
    .array_i   (array_rdata_i),
    .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0;
      op_kind_o  <= OP_NONE;
      op_addr_o  <= '0;
      op_data_o  <= '0;
    end else begin
      op_valid_o <= start_w;
      if (start_w) begin
        op_kind_o <= kind_w;
        op_addr_o <= addr_i;
        op_data_o <= wdata_i;
      end
    end
  end

  assign busy_o = busy_w;

  // R2: busy only ever rises together with a start pulse
  a_r2_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> op_valid_o);
  // R5: no start while busy
  a_r5_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_w);
  // R6: ID mode and busy never overlap
  a_r6_id_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_mode && busy_o));
  // R8: gated strobes never start anything
  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni || ce_ni) |=> !op_valid_o);
  // R9: status word carries only the toggle bit
  a_r9_status_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rdata_o & ~(DATA_W'(1) << TOGGLE_BIT)) == '0);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int unsigned PROG_N = 8;
  localparam int unsigned SECT_N = 20;
  localparam int unsigned CHIP_N = 40;
  localparam logic [15:0] DEV    = 16'h2782;
  localparam logic [15:0] ARRAY  = 16'h5A5A;
  localparam int unsigned NVEC   = 20;

  // {addr, data, expect start, expect kind}
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h2AAA, 16'h0055, 1'b0, 2'd0},
    {16'h5555, 16'h00A0, 1'b0, 2'd0},
    {16'h0123, 16'hBEEF, 1'b1, 2'd1},
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h2AAA, 16'h0055, 1'b0, 2'd0},
    {16'h5555, 16'h0080, 1'b0, 2'd0},
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h2AAA, 16'h0055, 1'b0, 2'd0},
    {16'h0400, 16'h0030, 1'b1, 2'd2},
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h2AAA, 16'h0055, 1'b0, 2'd0},
    {16'h5555, 16'h0080, 1'b0, 2'd0},
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h2AAA, 16'h0055, 1'b0, 2'd0},
    {16'h5555, 16'h0010, 1'b1, 2'd3},
    {16'h5555, 16'h00AA, 1'b0, 2'd0},
    {16'h1234, 16'h0055, 1'b0, 2'd0},
    {16'h5555, 16'h00A0, 1'b0, 2'd0},
    {16'h0777, 16'h1111, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic we_n = 1'b1, oe_n = 1'b1, ce_n = 1'b0;
  logic [15:0] rdata, op_addr, op_data;
  logic busy, op_valid;
  logic [1:0] op_kind;

  logic c_v;
  logic [1:0] c_k;
  logic [15:0] c_a, c_d;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(16), .DATA_W(16), .DEV_ID(DEV),
    .PROG_CYC(PROG_N), .SECT_CYC(SECT_N), .CHIP_CYC(CHIP_N)
  ) i_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_ni(we_n), .oe_ni(oe_n), .ce_ni(ce_n), .array_rdata_i(ARRAY),
    .rdata_o(rdata), .busy_o(busy), .op_valid_o(op_valid),
    .op_kind_o(op_kind), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d,
                    input logic ce_v = 1'b0, input logic oe_v = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    c_v = op_valid; c_k = op_kind; c_a = op_addr; c_d = op_data;
    ce_n = 1'b0; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; oe_n = 1'b0;
    @(negedge clk);
    d = rdata;
    oe_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = busy ? 1 : 0;
    while (busy) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] r;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 op_valid", 32'(op_valid), 0);
    chk("R1 rdata", 32'(rdata), 32'(ARRAY));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after release", 32'(rdata), 32'(ARRAY));

    // vector walk: R2 program, R3 erases, R4 abort
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] va, vd;
      logic vv;
      logic [1:0] vk;
      {va, vd, vv, vk} = VEC[i];
      wr(va, vd);
      if (vk == 2'd1) chk("R2 start", 32'(c_v), 32'(vv));
      else if (vv)    chk("R3 start", 32'(c_v), 32'(vv));
      else            chk("R4 no start", 32'(c_v), 32'(vv));
      if (vv) begin
        chk(vk == 2'd1 ? "R2 kind" : "R3 kind", 32'(c_k), 32'(vk));
        chk(vk == 2'd1 ? "R2 addr" : "R3 addr", 32'(c_a), 32'(va));
        if (vk == 2'd1) chk("R2 data", 32'(c_d), 32'(vd));
        busy_len(n);
        chk(vk == 2'd1 ? "R2 busy len" : "R3 busy len", 32'(n),
            vk == 2'd1 ? PROG_N : (vk == 2'd2 ? SECT_N : CHIP_N));
        chk("R10 busy low", 32'(busy), 0);
        chk("R10 array back", 32'(rdata), 32'(ARRAY));
      end
    end
    chk("R4 idle after abort", 32'(busy), 0);

    // R9 toggle during sector erase
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h0800, 16'h0030);
    chk("R3 sector start", 32'(c_v), 1);
    rd(16'h0000, r); chk("R9 read1", 32'(r), 32'h0000);
    rd(16'h0000, r); chk("R9 read2", 32'(r), 32'h0040);
    rd(16'h0000, r); chk("R9 read3", 32'(r), 32'h0000);
    busy_len(n);
    chk("R10 array after erase", 32'(rdata), 32'(ARRAY));

    // R5 commands ignored while busy (bank erase)
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0010);
    chk("R3 bank start", 32'(c_v), 1);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    chk("R5 id entry ignored no start", 32'(c_v), 0);
    wr(16'h0042, 16'h0099);
    chk("R5 no start while busy", 32'(c_v), 0);
    busy_len(n);
    rd(16'h0000, r); chk("R5 not in id mode", 32'(r), 32'(ARRAY));

    // R6 id mode reads
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    rd(16'h0000, r); chk("R6 mfr code", 32'(r), 32'h00BF);
    rd(16'h0001, r); chk("R6 dev code", 32'(r), 32'(DEV));
    rd(16'h0002, r); chk("R6 other addr", 32'(r), 32'h0000);
    // R7 persists across stray write, leaves via exit sequence
    wr(16'h1234, 16'h0000);
    rd(16'h0000, r); chk("R7 still id", 32'(r), 32'h00BF);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0);
    rd(16'h0000, r); chk("R7 exit to array", 32'(r), 32'(ARRAY));

    // R8 gated strobes ignored and leave pending sequence intact
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(16'h0100, 16'hCAFE, 1'b1, 1'b1);
    chk("R8 ce high ignored", 32'(c_v), 0);
    wr(16'h0100, 16'hCAFE, 1'b0, 1'b0);
    chk("R8 oe low ignored", 32'(c_v), 0);
    chk("R8 not busy", 32'(busy), 0);
    wr(16'h0100, 16'hCAFE);
    chk("R8 pending program starts", 32'(c_v), 1);
    chk("R8 program addr", 32'(c_a), 32'h0100);
    busy_len(n);
    chk("R2 busy len again", 32'(n), PROG_N);

    summary();
  end
endmodule